// File: doc/BRIEF.md
# Speculative-Fault Poison Register File

This block is a small general-purpose register file in which every entry carries one extra tag bit marking its contents as invalid. It lets a statically scheduled pipeline hoist instructions above branches without raising faults too early. A speculative operation that suffers a fatal fault does not trap. It sets the tag on its destination instead. The tag is carried forward through later speculative operations and only turns into an exception when a non-speculative operation actually consumes the value.

Each cycle the pipeline presents at most one operation. The operation names up to two sources, each with its own use flag, and an optional destination with write data. It also carries a speculative flag and two fault flags: one says a fault happened, the other says whether that fault is of the fatal kind. The two read ports return data combinationally from the state stored before the edge.

A separate check port, issued where the hoisted operation originally sat, tests one entry's tag. If the tag is set, the block asks for recovery code to run instead of trapping. Resumable faults are handed straight to the service path whether or not the operation is speculative, because servicing them only costs time.

Top module: `spec_poison_regfile`

## Requirements
- R1: Reset clears every tag bit, and `trap_valid`, `svc_req` and `rcv_valid` are low during reset and in the first cycle after it, so a check of any entry after reset requests no recovery.
- R2: A valid non-speculative operation with `op_we` high, no fault and no tagged used source stores `op_wdata` at `op_dst`. The value appears on the read ports from the next cycle.
- R3: A valid speculative operation with `op_we` high and a fatal fault (`op_fault`=1, `op_fault_term`=1) raises no trap, sets the destination's tag and leaves the destination's data unchanged.
- R4: A valid non-speculative operation with a tagged used source raises `trap_valid` one cycle later with `trap_cause`=1. `trap_reg` is source A's index if A is tagged and used, otherwise source B's. Nothing is written, and this outcome takes precedence over any fault flags on the same operation.
- R5: A valid speculative operation with a tagged used source and `op_we` high sets the destination's tag, keeps its data and raises no trap.
- R6: A check (`chk_valid`=1) raises `rcv_valid` with `rcv_reg`=`chk_reg` one cycle later exactly when that entry's tag was set before the edge. A write to the same entry in the same cycle is not seen by that check.
- R7: A resumable fault (`op_fault`=1, `op_fault_term`=0) on a valid operation raises `svc_req` one cycle later, whether speculative or not (unless R4 applies). There is no write, no tag change and no trap.
- R8: A valid non-speculative operation with a fatal fault and no tagged used source raises `trap_valid` with `trap_cause`=2 and `trap_reg`=`op_dst`. Nothing is written.
- R9: A source whose use flag is low is ignored for tag purposes, even when its entry is tagged.
- R10: A clean write (R2, or the same conditions on a speculative operation) clears the destination's tag.
- R11: With `op_valid` low, the operation fields cause no write, no tag change, no trap and no service request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_spec | input | 1 | The operation is speculative |
| op_use_a | input | 1 | Source A is consumed |
| op_src_a | input | AW | Source A index, also drives read port A |
| op_use_b | input | 1 | Source B is consumed |
| op_src_b | input | AW | Source B index, also drives read port B |
| op_we | input | 1 | The operation has a destination |
| op_dst | input | AW | Destination index |
| op_wdata | input | DW | Result to write |
| op_fault | input | 1 | The operation faulted |
| op_fault_term | input | 1 | The fault is of the fatal kind |
| chk_valid | input | 1 | Check operation this cycle |
| chk_reg | input | AW | Entry to check |
| rd_a_data | output | DW | Data stored at `op_src_a` |
| rd_b_data | output | DW | Data stored at `op_src_b` |
| trap_valid | output | 1 | Exception raised (one-cycle pulse) |
| trap_cause | output | 2 | 0 none, 1 tagged source read, 2 fatal fault |
| trap_reg | output | AW | Entry index tied to the exception |
| svc_req | output | 1 | Resumable fault service request (pulse) |
| rcv_valid | output | 1 | Recovery requested by a check (pulse) |
| rcv_reg | output | AW | Entry whose check requested recovery |

## Verification
The bench builds the block with eight entries of 16 bits. That small size makes it easy to fill every entry with a distinct value and see from the read port whether a suppressed write left old data in place. With only eight tags, the bench can also sweep every entry through the check port after a mid-run reset. The stimulus table walks the precedence chain: a tagged source beats a resumable fault, which beats a fatal fault. It covers tag propagation into a register that is itself the tagged source, and a check that shares its cycle with a tagging write.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_POISON = 2'd1,
    CAUSE_FAULT  = 2'd2
  } cause_e;

  typedef struct packed {
    logic commit;   // write data into the destination
    logic set_tag;  // mark destination as poisoned
    logic clr_tag;  // mark destination as clean
  } act_t;

endpackage

// File: rtl/spr_classify.sv
module spr_classify
  import spr_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          op_valid,
  input  logic          op_spec,
  input  logic          op_use_a,
  input  logic [AW-1:0] op_src_a,
  input  logic          op_use_b,
  input  logic [AW-1:0] op_src_b,
  input  logic          op_we,
  input  logic [AW-1:0] op_dst,
  input  logic          op_fault,
  input  logic          op_fault_term,
  input  logic          tag_a,
  input  logic          tag_b,
  output act_t          act,
  output logic          trap_now,
  output cause_e        trap_why,
  output logic [AW-1:0] trap_idx,
  output logic          svc_now
);

  logic a_bad, b_bad, src_bad, resumable, fatal;

  always_comb begin
    a_bad     = op_use_a & tag_a;
    b_bad     = op_use_b & tag_b;
    src_bad   = a_bad | b_bad;
    resumable = op_fault & ~op_fault_term;
    fatal     = op_fault & op_fault_term;

    act      = '0;
    trap_now = 1'b0;
    trap_why = CAUSE_NONE;
    trap_idx = '0;
    svc_now  = 1'b0;

    if (op_valid) begin
      if (!op_spec) begin
        if (src_bad) begin
          trap_now = 1'b1;
          trap_why = CAUSE_POISON;
          trap_idx = a_bad ? op_src_a : op_src_b;
        end else if (resumable) begin
          svc_now = 1'b1;
        end else if (fatal) begin
          trap_now = 1'b1;
          trap_why = CAUSE_FAULT;
          trap_idx = op_dst;
        end else if (op_we) begin
          act.commit  = 1'b1;
          act.clr_tag = 1'b1;
        end
      end else begin
        if (resumable) begin
          svc_now = 1'b1;
        end else if (op_we) begin
          if (fatal || src_bad) begin
            act.set_tag = 1'b1;
          end else begin
            act.commit  = 1'b1;
            act.clr_tag = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spr_tag_array.sv
module spr_tag_array #(
  parameter int NREG = 16,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   idx_a,
  input  logic [AW-1:0]   idx_b,
  input  logic [AW-1:0]   idx_chk,
  input  logic            set_en,
  input  logic            clr_en,
  input  logic [AW-1:0]   wr_idx,
  output logic            tag_a,
  output logic            tag_b,
  output logic            tag_chk,
  output logic [NREG-1:0] tags
);

  logic [NREG-1:0] tag_q, tag_d;

  for (genvar i = 0; i < NREG; i++) begin : g_tag
    always_comb begin
      tag_d[i] = tag_q[i];
      if (wr_idx == AW'(i)) begin
        if (set_en)      tag_d[i] = 1'b1;
        else if (clr_en) tag_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= tag_d;
  end

  assign tag_a   = tag_q[idx_a];
  assign tag_b   = tag_q[idx_b];
  assign tag_chk = tag_q[idx_chk];
  assign tags    = tag_q;

endmodule

// File: rtl/spr_data_array.sv
module spr_data_array #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int AW   = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_idx_a,
  input  logic [AW-1:0] rd_idx_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b
);

  logic [DW-1:0] mem_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == AW'(i));
    always_ff @(posedge clk) begin
      if (ent_en) mem_q[i] <= wr_data;
    end
  end

  assign rd_data_a = mem_q[rd_idx_a];
  assign rd_data_b = mem_q[rd_idx_b];

endmodule

// File: rtl/spec_poison_regfile.sv
module spec_poison_regfile
  import spr_pkg::*;
#(
  parameter  int NREG = 16,
  parameter  int DW   = 32,
  localparam int AW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_spec,
  input  logic          op_use_a,
  input  logic [AW-1:0] op_src_a,
  input  logic          op_use_b,
  input  logic [AW-1:0] op_src_b,
  input  logic          op_we,
  input  logic [AW-1:0] op_dst,
  input  logic [DW-1:0] op_wdata,
  input  logic          op_fault,
  input  logic          op_fault_term,
  input  logic          chk_valid,
  input  logic [AW-1:0] chk_reg,
  output logic [DW-1:0] rd_a_data,
  output logic [DW-1:0] rd_b_data,
  output logic          trap_valid,
  output logic [1:0]    trap_cause,
  output logic [AW-1:0] trap_reg,
  output logic          svc_req,
  output logic          rcv_valid,
  output logic [AW-1:0] rcv_reg
);

  logic            tag_a, tag_b, tag_chk;
  logic [NREG-1:0] tags;
  act_t            act;
  logic            trap_now, svc_now;
  cause_e          trap_why;
  logic [AW-1:0]   trap_idx;

  spr_classify #(.AW(AW)) u_cls (
    .op_valid     (op_valid),
    .op_spec      (op_spec),
    .op_use_a     (op_use_a),
    .op_src_a     (op_src_a),
    .op_use_b     (op_use_b),
    .op_src_b     (op_src_b),
    .op_we        (op_we),
    .op_dst       (op_dst),
    .op_fault     (op_fault),
    .op_fault_term(op_fault_term),
    .tag_a        (tag_a),
    .tag_b        (tag_b),
    .act          (act),
    .trap_now     (trap_now),
    .trap_why     (trap_why),
    .trap_idx     (trap_idx),
    .svc_now      (svc_now)
  );

  spr_tag_array #(.NREG(NREG), .AW(AW)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_a  (op_src_a),
    .idx_b  (op_src_b),
    .idx_chk(chk_reg),
    .set_en (act.set_tag),
    .clr_en (act.clr_tag),
    .wr_idx (op_dst),
    .tag_a  (tag_a),
    .tag_b  (tag_b),
    .tag_chk(tag_chk),
    .tags   (tags)
  );

  spr_data_array #(.NREG(NREG), .DW(DW), .AW(AW)) u_data (
    .clk      (clk),
    .wr_en    (act.commit),
    .wr_idx   (op_dst),
    .wr_data  (op_wdata),
    .rd_idx_a (op_src_a),
    .rd_idx_b (op_src_b),
    .rd_data_a(rd_a_data),
    .rd_data_b(rd_b_data)
  );

  // Event outputs: next-state then registers
  logic          trap_v_d, svc_d, rcv_v_d;
  logic [1:0]    trap_c_d;
  logic [AW-1:0] trap_r_d, rcv_r_d;
  logic          trap_r_en, rcv_r_en;

  always_comb begin
    trap_v_d  = trap_now;
    trap_c_d  = trap_why;
    trap_r_en = trap_now;
    trap_r_d  = trap_idx;
    svc_d     = svc_now;
    rcv_v_d   = chk_valid & tag_chk;
    rcv_r_en  = rcv_v_d;
    rcv_r_d   = chk_reg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_valid <= 1'b0;
      trap_cause <= 2'd0;
      svc_req    <= 1'b0;
      rcv_valid  <= 1'b0;
    end else begin
      trap_valid <= trap_v_d;
      trap_cause <= trap_c_d;
      svc_req    <= svc_d;
      rcv_valid  <= rcv_v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_reg <= '0;
      rcv_reg  <= '0;
    end else begin
      if (trap_r_en) trap_reg <= trap_r_d;
      if (rcv_r_en)  rcv_reg  <= rcv_r_d;
    end
  end

  AST_TRAP_ONLY_NONSPEC: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> $past(op_valid && !op_spec)); // R4

  AST_POISON_TRAP_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_cause == 2'd1) |-> tags[trap_reg]); // R4

  AST_RCV_FROM_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_valid |-> ($past(chk_valid) && rcv_reg == $past(chk_reg))); // R6

  AST_SVC_TRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_valid, svc_req})); // R7

  AST_TAG_RISE_NEEDS_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
    ((tags & ~$past(tags)) != '0) |-> $past(op_valid && op_spec)); // R3

  AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!op_valid) |-> (!trap_valid && !svc_req)); // R11

endmodule

// File: tb/spec_poison_regfile_bench.sv
module spec_poison_regfile_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int AW   = 3;

  typedef struct packed {
    logic [3:0]    rq;
    logic          val;
    logic          spec;
    logic          ua;
    logic [AW-1:0] a;
    logic          ub;
    logic [AW-1:0] b;
    logic          we;
    logic [AW-1:0] wa;
    logic [DW-1:0] wd;
    logic          f;
    logic          ft;
    logic          cv;
    logic [AW-1:0] cr;
    logic          xt;
    logic [1:0]    xc;
    logic [AW-1:0] xr;
    logic          xs;
    logic          xv;
    logic [AW-1:0] xrr;
    logic [DW-1:0] xra;
  } vec_t;

  localparam int NV = 32;
  // rq, val,spec,ua,a,ub,b,we,wa,wd,f,ft,cv,cr, xt,xc,xr,xs,xv,xrr,xra
  localparam vec_t TBL [NV] = '{
    '{2, 1,0,0,1,0,0,1,1,16'h1111,0,0,0,0, 0,0,0,0,0,0,16'h1111}, // R2
    '{2, 1,0,0,2,0,0,1,2,16'h2222,0,0,0,0, 0,0,0,0,0,0,16'h2222}, // R2
    '{2, 1,0,0,3,0,0,1,3,16'h3030,0,0,0,0, 0,0,0,0,0,0,16'h3030}, // R2
    '{2, 1,0,0,4,0,0,1,4,16'h0404,0,0,0,0, 0,0,0,0,0,0,16'h0404}, // R2
    '{2, 1,0,0,5,0,0,1,5,16'h0505,0,0,0,0, 0,0,0,0,0,0,16'h0505}, // R2
    '{2, 1,0,0,6,0,0,1,6,16'h0606,0,0,0,0, 0,0,0,0,0,0,16'h0606}, // R2
    '{3, 1,1,1,1,0,0,1,3,16'hDEAD,1,1,0,0, 0,0,0,0,0,0,16'h1111}, // R3 spec fatal -> tag r3
    '{3, 0,0,0,3,0,0,0,0,16'h0000,0,0,1,3, 0,0,0,0,1,3,16'h3030}, // R3 data kept, R6 check hit
    '{6, 0,0,0,2,0,0,0,0,16'h0000,0,0,1,2, 0,0,0,0,0,0,16'h2222}, // R6 clean check
    '{4, 1,0,1,3,0,0,1,4,16'h4444,0,0,0,0, 1,1,3,0,0,0,16'h3030}, // R4 trap on A
    '{4, 0,0,0,4,0,0,0,0,16'h0000,0,0,0,0, 0,0,0,0,0,0,16'h0404}, // R4 write suppressed
    '{4, 1,0,1,1,1,3,1,4,16'h4444,0,0,0,0, 1,1,3,0,0,0,16'h1111}, // R4 trap on B
    '{5, 1,1,1,3,0,0,1,6,16'h6666,0,0,0,0, 0,0,0,0,0,0,16'h3030}, // R5 propagate to r6
    '{5, 0,0,0,6,0,0,0,0,16'h0000,0,0,1,6, 0,0,0,0,1,6,16'h0606}, // R5 r6 tagged, data kept
    '{4, 1,0,1,6,1,3,0,0,16'h0000,0,0,0,0, 1,1,6,0,0,0,16'h0606}, // R4 A has priority
    '{9, 1,0,0,3,1,2,1,5,16'h5555,0,0,0,0, 0,0,0,0,0,0,16'h3030}, // R9 unused tagged src
    '{9, 0,0,0,5,0,0,0,0,16'h0000,0,0,0,0, 0,0,0,0,0,0,16'h5555}, // R9 write went through
    '{7, 1,0,1,1,0,0,1,1,16'hBEEF,1,0,0,0, 0,0,0,1,0,0,16'h1111}, // R7 nonspec resumable
    '{7, 1,1,1,2,0,0,1,2,16'hBEEF,1,0,0,0, 0,0,0,1,0,0,16'h2222}, // R7 spec resumable
    '{8, 1,0,0,5,0,0,1,5,16'h9999,1,1,0,0, 1,2,5,0,0,0,16'h5555}, // R8 nonspec fatal
    '{4, 1,0,1,3,0,0,1,1,16'hBEEF,1,0,0,0, 1,1,3,0,0,0,16'h3030}, // R4 beats resumable
    '{10,1,0,0,3,0,0,1,3,16'h3333,0,0,0,0, 0,0,0,0,0,0,16'h3333}, // R10 clean overwrite
    '{10,0,0,0,3,0,0,0,0,16'h0000,0,0,1,3, 0,0,0,0,0,0,16'h3333}, // R10 tag gone
    '{10,1,0,1,3,0,0,1,4,16'h4444,0,0,0,0, 0,0,0,0,0,0,16'h3333}, // R10 r3 readable
    '{10,0,0,0,4,0,0,0,0,16'h0000,0,0,0,0, 0,0,0,0,0,0,16'h4444}, // R2
    '{10,1,1,0,6,0,0,1,6,16'h6060,0,0,0,0, 0,0,0,0,0,0,16'h6060}, // R10 spec clean write
    '{10,0,0,0,6,0,0,0,0,16'h0000,0,0,1,6, 0,0,0,0,0,0,16'h6060}, // R10 tag gone
    '{11,0,0,1,1,0,0,1,1,16'hAAAA,1,1,0,0, 0,0,0,0,0,0,16'h1111}, // R11 invalid op
    '{6, 1,1,0,4,0,0,1,4,16'hDEAD,1,1,1,4, 0,0,0,0,0,0,16'h4444}, // R6 check sees old tag
    '{6, 0,0,0,4,0,0,0,0,16'h0000,0,0,1,4, 0,0,0,0,1,4,16'h4444}, // R6 now tagged
    '{5, 1,1,1,4,0,0,1,4,16'h7777,0,0,0,0, 0,0,0,0,0,0,16'h4444}, // R5 self propagate
    '{5, 1,0,1,4,0,0,0,0,16'h0000,0,0,0,0, 1,1,4,0,0,0,16'h4444}  // R5 still tagged
  };

  logic          clk, rst_n;
  logic          op_valid, op_spec, op_use_a, op_use_b, op_we, op_fault, op_fault_term;
  logic [AW-1:0] op_src_a, op_src_b, op_dst, chk_reg;
  logic [DW-1:0] op_wdata;
  logic          chk_valid;
  logic [DW-1:0] rd_a_data, rd_b_data;
  logic          trap_valid, svc_req, rcv_valid;
  logic [1:0]    trap_cause;
  logic [AW-1:0] trap_reg, rcv_reg;

  int n_chk, n_bad;
  logic done;

  spec_poison_regfile #(.NREG(NREG), .DW(DW)) u_spec_poison_regfile (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_spec(op_spec),
    .op_use_a(op_use_a), .op_src_a(op_src_a),
    .op_use_b(op_use_b), .op_src_b(op_src_b),
    .op_we(op_we), .op_dst(op_dst), .op_wdata(op_wdata),
    .op_fault(op_fault), .op_fault_term(op_fault_term),
    .chk_valid(chk_valid), .chk_reg(chk_reg),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_reg(trap_reg),
    .svc_req(svc_req), .rcv_valid(rcv_valid), .rcv_reg(rcv_reg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input vec_t v);
    op_valid = v.val; op_spec = v.spec;
    op_use_a = v.ua;  op_src_a = v.a;
    op_use_b = v.ub;  op_src_b = v.b;
    op_we = v.we; op_dst = v.wa; op_wdata = v.wd;
    op_fault = v.f; op_fault_term = v.ft;
    chk_valid = v.cv; chk_reg = v.cr;
  endtask

  task automatic idle();
    vec_t z;
    z = '0;
    drive(z);
  endtask

  task automatic expect_events(input string tag, input logic xt, input logic xs,
                               input logic xv, input logic [AW-1:0] xrr);
    n_chk++;
    if (trap_valid !== xt || svc_req !== xs || rcv_valid !== xv ||
        (xv && rcv_reg !== xrr)) begin
      n_bad++;
      $display("FAIL %s: actual trap=%0b svc=%0b rcv=%0b rreg=%0d expected trap=%0b svc=%0b rcv=%0b rreg=%0d",
               tag, trap_valid, svc_req, rcv_valid, rcv_reg, xt, xs, xv, xrr);
    end
  endtask

  initial begin
    done = 1'b0;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    expect_events("R1 in reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    @(posedge clk); #(CLK_PERIOD/4);
    expect_events("R1 after release", 0, 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      @(negedge clk);
      drive(v);
      @(posedge clk);
      #(CLK_PERIOD/4);
      n_chk++;
      if (trap_valid !== v.xt || svc_req !== v.xs || rcv_valid !== v.xv ||
          (v.xt && (trap_cause !== v.xc || trap_reg !== v.xr)) ||
          (v.xv && rcv_reg !== v.xrr) || rd_a_data !== v.xra) begin
        n_bad++;
        $display("FAIL R%0d vec %0d: actual trap=%0b/%0d/%0d svc=%0b rcv=%0b/%0d rd=%h expected trap=%0b/%0d/%0d svc=%0b rcv=%0b/%0d rd=%h",
                 v.rq, i, trap_valid, trap_cause, trap_reg, svc_req, rcv_valid, rcv_reg, rd_a_data,
                 v.xt, v.xc, v.xr, v.xs, v.xv, v.xrr, v.xra);
      end
    end

    // R1: tag r2 speculatively, confirm, then reset and sweep every entry
    @(negedge clk);
    idle(); op_valid = 1; op_spec = 1; op_we = 1; op_dst = 2;
    op_fault = 1; op_fault_term = 1;
    @(negedge clk);
    idle(); chk_valid = 1; chk_reg = 2;
    @(posedge clk); #(CLK_PERIOD/4);
    expect_events("R3 tag before reset", 0, 0, 1, 2);
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < NREG; r++) begin
      @(negedge clk);
      idle(); chk_valid = 1; chk_reg = AW'(r);
      @(posedge clk); #(CLK_PERIOD/4);
      expect_events("R1 tags cleared", 0, 0, 0, 0);
    end
    // R1: non-speculative read of formerly tagged r2 must not trap
    @(negedge clk);
    idle(); op_valid = 1; op_use_a = 1; op_src_a = 2;
    @(posedge clk); #(CLK_PERIOD/4);
    expect_events("R1 no trap after reset", 0, 0, 0, 0);
    @(negedge clk);
    idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule